// File: doc/BRIEF.md
# Minimal UART Register File

This block is the register side of a bare-bones serial port. A processor reaches it over a small byte bus with a 3-bit offset, separate read and write strobes, write data, combinational read data and an error flag. The classic eight-slot register layout is kept. A bank-select bit in the line control register (bit 7) swaps offsets 0 and 1 over to the two divisor bytes. While that bit is set, all reads are refused.

There is no bit-level serial engine and there are no FIFOs. A byte written to the data slot leaves at once on a transmit output as a one-cycle pulse. A byte arriving on the receive side is held in a single slot until software reads it. The divisor bytes and the FIFO control byte are only stored, and they are presented as configuration outputs. The modem control and scratch slots are plain storage. A single level interrupt follows a deliberately simple rule. It rises when the transmit-empty enable is set or received data is waiting. It stays up until a transmit write or a read of the received byte knocks it down.

Top module: `lite_uart_regs`

## Requirements
- R1: After reset, reads return 0x01 at offset 2 (the "no interrupt" bit 0 set), 0x20 at offset 5, 0x10 at offset 6 and zero at offsets 0, 1, 3, 4 and 7. At that point irq, tx_valid, div_value and fifo_ctrl are all zero and rx_ready is high.
- R2: With the bank bit clear, offset 6 always reads 0x10. Offset 5 always reads with bit 5 set (transmit empty), and its bit 0 equals the data-ready flag.
- R3: With the bank bit (offset 3, bit 7) set, the following writes take effect: offset 0 writes the divisor low byte, offset 1 the divisor high byte, offset 2 the FIFO control byte and offset 3 the line control byte. A write to offsets 4 to 7 raises bus_err in the same cycle and changes nothing.
- R4: With the bank bit set, every read raises bus_err in the same cycle and returns 0x00. Such a read has no side effect; in particular a waiting received byte stays pending.
- R5: With the bank bit clear, a write to offset 0 drives tx_data with the written byte and tx_valid high for exactly the next cycle. The same write forces irq low, and IIR bit 0 high, in the next cycle.
- R6: rx_ready equals the inverse of data-ready. A receive byte offered while rx_ready is high is latched at that clock edge, and data-ready is set.
- R7: While data-ready is set, a byte held on rx_data with rx_valid high does not replace the latched byte. It is taken only on the cycle after the latched byte has been read.
- R8: With the bank bit clear and data-ready set, a read of offset 0 returns the latched byte in the same cycle. It then clears data-ready and drops irq in the next cycle. The same read with data-ready clear returns 0x00 and changes no state.
- R9: In any cycle that carries no transmit write and no clearing receive read, the interrupt is raised on the next cycle if IER bit 1 is set or data-ready is set: irq goes high and IIR bit 0 reads 0. Otherwise irq keeps its value. This means irq comes back one cycle after a transmit write while IER bit 1 stays set.
- R10: IER bit 0 is stored and read back at offset 1, but it never raises the interrupt by itself.
- R11: With the bank bit clear, offsets 1, 3, 4 and 7 are plain read/write storage. A write to offset 5 or 6 raises bus_err in the same cycle and changes nothing.
- R12: div_value presents {divisor high, divisor low} and fifo_ctrl presents the last FIFO control byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle, zero otherwise |
| bus_err | output | 1 | Access rejected, same cycle as the strobe |
| tx_data | output | 8 | Last transmitted byte |
| tx_valid | output | 1 | One-cycle pulse marking a transmitted byte |
| rx_data | input | 8 | Received byte offered by the host side |
| rx_valid | input | 1 | rx_data is valid |
| rx_ready | output | 1 | Receive slot is empty and will take a byte |
| irq | output | 1 | Level interrupt |
| div_value | output | 16 | Stored divisor, high byte first |
| fifo_ctrl | output | 8 | Stored FIFO control byte |

## Verification
The embedded properties check several rules on every clock: a held receive byte never changes while it is pending, and a clearing read empties the slot. A transmit write or clearing read always drops the interrupt, and an enabled source raises it one cycle later. Banked reads are always refused, every transmit pulse traces back to a data write, and offset 6 always reads as clear-to-send. The bench scenarios show what a single property cannot. These are the reset contents, the divisor and FIFO bytes landing through the bank, and the storage read-backs. They also cover the one-byte back-pressure sequence from offer to read, the interrupt returning after a transmit write, and IER bit 0 having no effect on the interrupt.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;

    localparam int DW = 8;
    localparam int AW = 3;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [AW-1:0] {
        OFS_DATA    = 3'd0,
        OFS_IEN     = 3'd1,
        OFS_IDENT   = 3'd2,
        OFS_LINE    = 3'd3,
        OFS_MODEM   = 3'd4,
        OFS_STAT    = 3'd5,
        OFS_MSTAT   = 3'd6,
        OFS_SCRATCH = 3'd7
    } ofs_e;

    // storage slots held by the register file
    localparam int ST_IEN     = 0;
    localparam int ST_LINE    = 1;
    localparam int ST_MODEM   = 2;
    localparam int ST_SCRATCH = 3;
    localparam int ST_DIV_LO  = 4;
    localparam int ST_DIV_HI  = 5;
    localparam int ST_FIFO    = 6;
    localparam int N_STORE    = 7;

    localparam int BANK_BIT     = 7;  // line control: divisor bank select
    localparam int TXE_EN_BIT   = 1;  // interrupt enable: transmit empty
    localparam int STAT_DR_BIT  = 0;  // status: data ready
    localparam int STAT_TE_BIT  = 5;  // status: transmit holding empty
    localparam int IDENT_NONE   = 0;  // ident: no interrupt pending

    localparam byte_t MSTAT_VALUE = 8'h10;

    typedef struct packed {
        logic [N_STORE-1:0] st_we;  // per-slot write enable
        logic               wr_tx;  // transmit write
        logic               rd_rx;  // read of the receive slot
        logic               rd_ok;  // accepted read
        logic               err;    // rejected access
    } bus_cmd_t;

    function automatic byte_t stat_value(input logic ready);
        byte_t v;
        v = '0;
        v[STAT_TE_BIT] = 1'b1;
        v[STAT_DR_BIT] = ready;
        return v;
    endfunction

    function automatic byte_t ident_value(input logic none_pending);
        byte_t v;
        v = '0;
        v[IDENT_NONE] = none_pending;
        return v;
    endfunction

endpackage

// File: rtl/lite_uart_decode.sv
module lite_uart_decode
    import lite_uart_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic          bank,
    output bus_cmd_t      cmd
);
    ofs_e ofs;
    logic wr_bad;
    logic rd_bad;

    assign ofs = ofs_e'(addr);

    always_comb begin
        cmd = '0;
        wr_bad = 1'b0;
        if (wr) begin
            if (bank) begin
                unique case (ofs)
                    OFS_DATA:  cmd.st_we[ST_DIV_LO] = 1'b1;
                    OFS_IEN:   cmd.st_we[ST_DIV_HI] = 1'b1;
                    OFS_IDENT: cmd.st_we[ST_FIFO]   = 1'b1;
                    OFS_LINE:  cmd.st_we[ST_LINE]   = 1'b1;
                    default:   wr_bad = 1'b1;
                endcase
            end else begin
                unique case (ofs)
                    OFS_DATA:    cmd.wr_tx               = 1'b1;
                    OFS_IEN:     cmd.st_we[ST_IEN]       = 1'b1;
                    OFS_IDENT:   cmd.st_we[ST_FIFO]      = 1'b1;
                    OFS_LINE:    cmd.st_we[ST_LINE]      = 1'b1;
                    OFS_MODEM:   cmd.st_we[ST_MODEM]     = 1'b1;
                    OFS_SCRATCH: cmd.st_we[ST_SCRATCH]   = 1'b1;
                    default:     wr_bad = 1'b1;
                endcase
            end
        end
        rd_bad    = rd & bank;
        cmd.rd_ok = rd & ~bank;
        cmd.rd_rx = rd & ~bank & (ofs == OFS_DATA);
        cmd.err   = wr_bad | rd_bad;
    end

endmodule

// File: rtl/lite_uart_rx_hold.sv
module lite_uart_rx_hold
    import lite_uart_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t rx_data,
    input  logic  rx_valid,
    output logic  rx_ready,
    input  logic  rd_rx,
    output byte_t hold_byte,
    output logic  ready_flag
);
    logic take;
    logic release_slot;

    assign rx_ready     = ~ready_flag;
    assign take         = rx_valid & ~ready_flag;
    assign release_slot = rd_rx & ready_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_flag <= 1'b0;
            hold_byte  <= '0;
        end else if (take) begin
            ready_flag <= 1'b1;
            hold_byte  <= rx_data;
        end else if (release_slot) begin
            ready_flag <= 1'b0;
        end
    end

    // R6: an offered byte on an empty slot is latched at that edge
    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_ready |=> ready_flag && hold_byte == $past(rx_data));

    // R7: a pending byte is never replaced
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        ready_flag && !rd_rx |=> ready_flag && $stable(hold_byte));

    // R8: a read of a pending byte empties the slot
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ready_flag && rd_rx |=> !ready_flag);

endmodule

// File: rtl/lite_uart_irq.sv
module lite_uart_irq (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic txe_en,
    input  logic data_ready,
    output logic irq,
    output logic none_pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq          <= 1'b0;
            none_pending <= 1'b1;
        end else if (drop) begin
            irq          <= 1'b0;
            none_pending <= 1'b1;
        end else if (txe_en || data_ready) begin
            irq          <= 1'b1;
            none_pending <= 1'b0;
        end
    end

    // R5 / R8: a transmit write or clearing read lowers the line
    p_drop_r5: assert property (@(posedge clk) disable iff (rst)
        drop |=> !irq && none_pending);

    // R9: an enabled source raises the line one cycle later
    p_raise_r9: assert property (@(posedge clk) disable iff (rst)
        !drop && (txe_en || data_ready) |=> irq && !none_pending);

    // R9: only a drop event lowers the line
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !drop && irq |=> irq);

endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
    import lite_uart_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_err,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic        irq,
    output logic [15:0] div_value,
    output logic [7:0]  fifo_ctrl
);
    bus_cmd_t cmd;
    byte_t    store_q [N_STORE];
    byte_t    hold_byte;
    logic     data_ready;
    logic     none_pending;
    logic     bank;
    logic     drop;

    assign bank = store_q[ST_LINE][BANK_BIT];

    lite_uart_decode u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .bank (bank),
        .cmd  (cmd)
    );

    // plain storage slots, one register per slot
    for (genvar g = 0; g < N_STORE; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= '0;
            end else if (cmd.st_we[g]) begin
                store_q[g] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= cmd.wr_tx;
            if (cmd.wr_tx) begin
                tx_data <= bus_wdata;
            end
        end
    end

    lite_uart_rx_hold u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rd_rx      (cmd.rd_rx),
        .hold_byte  (hold_byte),
        .ready_flag (data_ready)
    );

    assign drop = cmd.wr_tx | (cmd.rd_rx & data_ready);

    lite_uart_irq u_irq (
        .clk          (clk),
        .rst          (rst),
        .drop         (drop),
        .txe_en       (store_q[ST_IEN][TXE_EN_BIT]),
        .data_ready   (data_ready),
        .irq          (irq),
        .none_pending (none_pending)
    );

    always_comb begin
        bus_rdata = '0;
        if (cmd.rd_ok) begin
            unique case (ofs_e'(bus_addr))
                OFS_DATA:    bus_rdata = data_ready ? hold_byte : '0;
                OFS_IEN:     bus_rdata = store_q[ST_IEN];
                OFS_IDENT:   bus_rdata = ident_value(none_pending);
                OFS_LINE:    bus_rdata = store_q[ST_LINE];
                OFS_MODEM:   bus_rdata = store_q[ST_MODEM];
                OFS_STAT:    bus_rdata = stat_value(data_ready);
                OFS_MSTAT:   bus_rdata = MSTAT_VALUE;
                OFS_SCRATCH: bus_rdata = store_q[ST_SCRATCH];
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign bus_err   = cmd.err;
    assign div_value = {store_q[ST_DIV_HI], store_q[ST_DIV_LO]};
    assign fifo_ctrl = store_q[ST_FIFO];

    // R4: banked reads are refused and return nothing
    p_bank_read_r4: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bank |-> bus_err && bus_rdata == 8'h00);

    // R5: every transmit pulse follows a data write in the unbanked view
    p_tx_origin_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bus_wr && bus_addr == 3'd0 && !bank));

    // R2: modem status always shows clear-to-send
    p_mstat_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rd && !bank && bus_addr == 3'd6 |-> bus_rdata == 8'h10);

endmodule

// File: tb/lite_uart_regs_tb.sv
module lite_uart_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_err;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready;
    logic        irq;
    logic [15:0] div_value;
    logic [7:0]  fifo_ctrl;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_lcr, m_ier, m_mcr, m_scr, m_dll, m_dlm, m_fcr;
    int m_rbr, m_txd;
    bit m_dr, m_iir0, m_irq, m_txv;

    always #(CLK_PERIOD/2) clk = ~clk;

    lite_uart_regs u_dut (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .irq(irq), .div_value(div_value), .fifo_ctrl(fifo_ctrl)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lcr = 0; m_ier = 0; m_mcr = 0; m_scr = 0;
        m_dll = 0; m_dlm = 0; m_fcr = 0; m_rbr = 0; m_txd = 0;
        m_dr = 0; m_iir0 = 1; m_irq = 0; m_txv = 0;
    endtask

    // one clock: drive, compare outputs, advance the model, cross the edge
    task automatic step(input string tag, input int a, input bit w, input bit r,
                        input int wd, input bit rv, input int rxd);
        bit dlab, exp_err, tx_wr, rx_rd, drop;
        int exp_rd;
        bus_addr = a[2:0]; bus_wr = w; bus_rd = r; bus_wdata = wd[7:0];
        rx_valid = rv; rx_data = rxd[7:0];
        #1;
        dlab = m_lcr[7];
        exp_err = (r && dlab) || (w && (dlab ? (a >= 4) : (a == 5 || a == 6)));
        exp_rd = 0;
        if (r && !dlab) begin
            case (a)
                0: exp_rd = m_dr ? m_rbr : 0;
                1: exp_rd = m_ier;
                2: exp_rd = m_iir0 ? 1 : 0;
                3: exp_rd = m_lcr;
                4: exp_rd = m_mcr;
                5: exp_rd = 'h20 | (m_dr ? 1 : 0);
                6: exp_rd = 'h10;
                default: exp_rd = m_scr;
            endcase
        end
        check(tag, "bus_rdata", bus_rdata, exp_rd);
        check(tag, "bus_err", bus_err, exp_err);
        check(tag, "tx_valid", tx_valid, m_txv);
        check(tag, "tx_data", tx_data, m_txd);
        check(tag, "rx_ready", rx_ready, !m_dr);
        check(tag, "irq", irq, m_irq);
        check(tag, "div_value", div_value, m_dlm * 256 + m_dll);
        check(tag, "fifo_ctrl", fifo_ctrl, m_fcr);
        // next state from the old state
        tx_wr = w && !dlab && a == 0;
        rx_rd = r && !dlab && a == 0 && m_dr;
        drop = tx_wr || rx_rd;
        if (drop) begin
            m_irq = 0; m_iir0 = 1;
        end else if (m_ier[1] || m_dr) begin
            m_irq = 1; m_iir0 = 0;
        end
        m_txv = tx_wr;
        if (tx_wr) m_txd = wd & 'hff;
        if (rv && !m_dr) begin
            m_rbr = rxd & 'hff; m_dr = 1;
        end else if (rx_rd) begin
            m_dr = 0;
        end
        if (w) begin
            if (dlab) begin
                case (a)
                    0: m_dll = wd & 'hff;
                    1: m_dlm = wd & 'hff;
                    2: m_fcr = wd & 'hff;
                    3: m_lcr = wd & 'hff;
                    default: ;
                endcase
            end else begin
                case (a)
                    1: m_ier = wd & 'hff;
                    2: m_fcr = wd & 'hff;
                    3: m_lcr = wd & 'hff;
                    4: m_mcr = wd & 'hff;
                    7: m_scr = wd & 'hff;
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input int a, input int d);
        step(tag, a, 1, 0, d, 0, 0);
    endtask

    task automatic rd(input string tag, input int a);
        step(tag, a, 0, 1, 0, 0, 0);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        rx_valid = 0; rx_data = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset contents, R2 status and modem status
        for (int a = 0; a < 8; a++) rd("R1", a);
        rd("R2", 6);
        rd("R2", 5);

        // R11 plain storage, R10 receive-enable bit alone raises nothing
        wr("R10", 1, 'h01);
        idle("R10"); idle("R10");
        rd("R10", 1);
        rd("R10", 2);
        wr("R11", 4, 'hA5);
        wr("R11", 7, 'h3C);
        wr("R11", 3, 'h1B);
        wr("R11", 5, 'hFF);
        wr("R11", 6, 'hFF);
        for (int a = 1; a < 8; a++) rd("R11", a);
        for (int i = 0; i < 6; i++) begin
            wr("R11", 7, (i * 37 + 5) & 'hff);
            rd("R11", 7);
        end

        // R3 banked writes, R4 banked reads, R12 configuration outputs
        wr("R3", 3, 'h83);
        wr("R3", 0, 'h12);
        wr("R3", 1, 'h34);
        wr("R3", 2, 'hC7);
        for (int a = 4; a < 8; a++) wr("R3", a, 'h99);
        for (int a = 0; a < 8; a++) rd("R4", a);
        wr("R3", 3, 'h03);
        idle("R12");
        rd("R3", 4);
        rd("R3", 7);
        rd("R3", 1);

        // R5 transmit pulse and R9 interrupt return with transmit-empty enable
        wr("R5", 0, 'h41);
        idle("R5");
        wr("R9", 1, 'h02);
        idle("R9"); idle("R9");
        rd("R9", 2);
        wr("R5", 0, 'h42);
        idle("R9");
        idle("R9");
        rd("R9", 2);
        wr("R5", 0, 'h43);
        wr("R5", 0, 'h44);
        idle("R5");

        // R9 the line stays up after the enable is cleared, until a drop
        wr("R9", 1, 'h00);
        idle("R9"); idle("R9");
        wr("R5", 0, 'h55);
        idle("R9"); idle("R9");

        // R6 accept, R7 back-pressure, R8 clearing read
        step("R6", 0, 0, 0, 0, 1, 'h5A);
        step("R7", 0, 0, 0, 0, 1, 'h77);
        step("R7", 5, 0, 1, 0, 1, 'h77);
        step("R7", 2, 0, 1, 0, 1, 'h77);
        step("R8", 0, 0, 1, 0, 1, 'h77);
        step("R7", 0, 0, 0, 0, 0, 0);
        rd("R8", 0);
        idle("R8");
        rd("R8", 0);
        rd("R8", 5);

        // R4 a banked read leaves a pending byte in place
        step("R6", 0, 0, 0, 0, 1, 'hC3);
        wr("R4", 3, 'h80);
        rd("R4", 0);
        rd("R4", 5);
        wr("R4", 3, 'h00);
        rd("R4", 5);
        rd("R8", 0);
        idle("R8"); idle("R8");
        rd("R1", 2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule